// File: doc/BRIEF.md
# Two-Slot Ping-Pong DMA Channel

This block is the control and status core of one peripheral DMA channel. It keeps two descriptor slots, each with a memory address, a transfer count and a command/status word. A channel control word selects and reports the slot in use and offers pause, flush, software reset and interrupt gating. Software programs the block through a simple register bus with a one-cycle write strobe and a combinational read path.

Data moves one byte per beat. Memory traffic goes out as held request/grant transactions. The peripheral side uses valid/ready handshakes. A small FIFO buffers the bytes between the two sides. Inbound transfers go from the peripheral to memory, and outbound transfers go from memory to the peripheral. When a slot's count runs out, the slot is marked finished and raises its flag. If the other slot is armed, the channel moves on to that slot with no idle cycle. Control and command writes use a polarity bit, so software can set or clear single bits without a read-modify-write.

Top module: `dma_pingpong_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is low and no memory request, peripheral ready or peripheral valid is asserted.
- R2: On a write to a control or command word, bit 15 chooses the polarity. With bit 15 at 1, each other bit written as 1 is set. With bit 15 at 0, each other bit written as 1 is cleared. Bits written as 0 keep their value, and bit 15 always reads 0.
- R3: Register offsets are 0x00 (address), 0x04 (count) and 0x08 (command) for slot 0, and the same plus 0x10 for slot 1. The control word sits at 0x20. Address and count take plain writes. Command bits are 8 done-flag, 9 direction, 10 count-exhausted, 11 armed and 12 flag-enable. Control bits are 0 active slot (read-only), 8 channel interrupt (read-only), 9 flush, 10 pause, 11 software reset (reads 0), 12 interrupt enable, 13 bus error and 14 frozen (read-only).
- R4: With direction 1 (inbound), the channel accepts peripheral bytes only while the FIFO holds fewer bytes than the remaining count. It writes them to consecutive addresses, but only when the FIFO is full, or holds the whole remaining count, or a flush is active. Each memory beat adds 1 to the address and subtracts 1 from the count.
- R5: With direction 0 (outbound), the channel reads consecutive addresses into the FIFO while the FIFO has room. It hands the bytes to the peripheral in order, and each memory beat adds 1 to the address and subtracts 1 from the count.
- R6: The beat that takes a slot's count from 1 to 0 sets that slot's done-flag and count-exhausted bits and clears its armed bit.
- R7: If the other slot is armed when the active slot finishes, control bit 0 switches to the other slot at the same clock edge, and the transfer carries on from that slot.
- R8: Control bit 8 and `irq` equal the interrupt enable ANDed with the OR, over both slots, of (done-flag AND flag-enable).
- R9: Once pause is set, a granted or already held memory beat still completes. Frozen rises only once no request is outstanding. While frozen there are no memory requests and no peripheral handshakes. Clearing pause clears frozen and lets the transfer resume.
- R10: Flush reads 1 while the FIFO holds data. It forces inbound bytes out to memory and clears itself once the FIFO is empty.
- R11: Software reset empties the FIFO and clears pause, flush, bus error, frozen and both armed bits, and selects slot 0. A count register may be written while the channel is paused, and it reads back the written value.
- R12: A memory beat answered with an error sets bus error and frozen and clears the active slot's armed bit. It leaves address and count unchanged.
- R13: A memory request that is not granted stays asserted, with its address, direction and write data stable, until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | BAW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes the beat |
| mem_err | input | 1 | Error response, qualified by mem_gnt |
| mem_rdata | input | 8 | Memory read data, valid with mem_gnt |
| pin_valid | input | 1 | Peripheral byte available (inbound) |
| pin_data | input | 8 | Peripheral byte (inbound) |
| pin_ready | output | 1 | Channel accepts a peripheral byte |
| pout_valid | output | 1 | Channel offers a byte to the peripheral |
| pout_data | output | 8 | Byte for the peripheral (outbound) |
| pout_ready | input | 1 | Peripheral accepts the byte |
| irq | output | 1 | Active-high channel interrupt |

## Verification
The assertions rely on four assumptions about the environment. Software does not rewrite the active slot's address or command while a memory request is held. Software reset is only issued when no request is outstanding. Two chained slots always share a direction. Memory answers with grant and error only against an asserted request. The bench keeps within these assumptions in three ways. It reprograms slots only after a software reset or while the channel is idle or frozen. It holds the grant low only when it wants to observe a held request. It injects a single error response only once a request is already present.

// File: rtl/dma_pingpong_chan.sv
module dma_pingpong_chan #(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  parameter int BAW   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [BAW-1:0] bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_wdata,
  input  logic           mem_gnt,
  input  logic           mem_err,
  input  logic [7:0]     mem_rdata,
  input  logic           pin_valid,
  input  logic [7:0]     pin_data,
  output logic           pin_ready,
  output logic           pout_valid,
  output logic [7:0]     pout_data,
  input  logic           pout_ready,
  output logic           irq
);

  localparam int PW = $clog2(DEPTH);
  localparam logic [BAW-1:0] CTL_OFS = BAW'(32);

  function automatic logic [BAW-1:0] reg_ofs(input int slot, input int idx);
    return BAW'(slot * 16 + idx * 4);
  endfunction

  logic [AW-1:0] addr_q [2];
  logic [CW-1:0] cnt_q  [2];
  logic [1:0] ifl_q, dir_q, tc_q, en_q, ie_q;
  logic act_q, pause_q, flush_q, cie_q, berr_q, frozen_q, busy_q;

  logic [7:0]    fifo_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   fcnt_q;

  logic sense, ctl_wr, swreset;
  assign sense   = bus_wdata[15];
  assign ctl_wr  = bus_wr && (bus_addr == CTL_OFS);
  assign swreset = ctl_wr && sense && bus_wdata[11];

  logic dir_a, en_a, fifo_full, fifo_empty, run, start_in, start;
  logic [CW-1:0] cnt_a;
  assign dir_a      = dir_q[act_q];
  assign en_a       = en_q[act_q];
  assign cnt_a      = cnt_q[act_q];
  assign fifo_full  = (fcnt_q == (PW+1)'(DEPTH));
  assign fifo_empty = (fcnt_q == '0);
  assign run        = en_a && !pause_q && !berr_q;
  assign start_in   = !fifo_empty && (fifo_full || flush_q || CW'(fcnt_q) == cnt_a);
  assign start      = run && (dir_a ? start_in : !fifo_full);

  logic beat, beat_ok, beat_err, last;
  assign mem_req   = busy_q || start;
  assign mem_we    = dir_a;
  assign mem_addr  = addr_q[act_q];
  assign mem_wdata = fifo_q[rp_q];
  assign beat      = mem_req && mem_gnt;
  assign beat_ok   = beat && !mem_err;
  assign beat_err  = beat && mem_err;
  assign last      = beat_ok && (cnt_a == CW'(1));

  assign pin_ready  = dir_a && run && !fifo_full && (CW'(fcnt_q) < cnt_a);
  assign pout_valid = !dir_a && !fifo_empty && !pause_q && !berr_q;
  assign pout_data  = fifo_q[rp_q];

  logic push, pop, chan_irq;
  logic [7:0] push_data;
  assign push      = (pin_valid && pin_ready) || (beat_ok && !dir_a);
  assign pop       = (beat_ok && dir_a) || (pout_valid && pout_ready);
  assign push_data = dir_a ? pin_data : mem_rdata;
  assign chan_irq  = cie_q && |(ifl_q & ie_q);
  assign irq       = chan_irq;

  logic [1:0] wr_addr, wr_cnt, wr_cmd, hit_beat, hit_last, hit_err;
  for (genvar g = 0; g < 2; g++) begin : g_slot
    assign wr_addr[g]  = bus_wr && (bus_addr == reg_ofs(g, 0));
    assign wr_cnt[g]   = bus_wr && (bus_addr == reg_ofs(g, 1));
    assign wr_cmd[g]   = bus_wr && (bus_addr == reg_ofs(g, 2));
    assign hit_beat[g] = beat_ok && (act_q == 1'(g));
    assign hit_last[g] = last && (act_q == 1'(g));
    assign hit_err[g]  = beat_err && (act_q == 1'(g));

    a_r6_done_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_last[g] && !wr_cmd[g]) |=> (tc_q[g] && ifl_q[g] && !en_q[g]));
  end

  logic pause_n, berr_n, flush_n, cie_n, act_n, busy_n, frozen_n;
  always_comb begin
    pause_n  = swreset ? 1'b0 : (ctl_wr && bus_wdata[10]) ? sense : pause_q;
    berr_n   = swreset ? 1'b0 : beat_err ? 1'b1 : (ctl_wr && bus_wdata[13]) ? sense : berr_q;
    flush_n  = swreset ? 1'b0 : (ctl_wr && bus_wdata[9]) ? sense : (fifo_empty ? 1'b0 : flush_q);
    cie_n    = (ctl_wr && bus_wdata[12]) ? sense : cie_q;
    act_n    = swreset ? 1'b0 : (last && en_q[~act_q]) ? ~act_q : act_q;
    busy_n   = mem_req && !mem_gnt && !swreset;
    frozen_n = (pause_n || berr_n) && !busy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q <= 1'b0; berr_q <= 1'b0; flush_q <= 1'b0; cie_q <= 1'b0;
      act_q <= 1'b0; busy_q <= 1'b0; frozen_q <= 1'b0;
    end else begin
      pause_q <= pause_n; berr_q <= berr_n; flush_q <= flush_n; cie_q <= cie_n;
      act_q <= act_n; busy_q <= busy_n; frozen_q <= frozen_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        addr_q[s] <= '0;
        cnt_q[s]  <= '0;
      end
      ifl_q <= '0; dir_q <= '0; tc_q <= '0; en_q <= '0; ie_q <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (wr_addr[s])       addr_q[s] <= AW'(bus_wdata);
        else if (hit_beat[s]) addr_q[s] <= addr_q[s] + AW'(1);
        if (wr_cnt[s])        cnt_q[s]  <= CW'(bus_wdata);
        else if (hit_beat[s]) cnt_q[s]  <= cnt_q[s] - CW'(1);
        ifl_q[s] <= (wr_cmd[s] && bus_wdata[8])  ? sense : (hit_last[s] ? 1'b1 : ifl_q[s]);
        dir_q[s] <= (wr_cmd[s] && bus_wdata[9])  ? sense : dir_q[s];
        tc_q[s]  <= (wr_cmd[s] && bus_wdata[10]) ? sense : (hit_last[s] ? 1'b1 : tc_q[s]);
        en_q[s]  <= (wr_cmd[s] && bus_wdata[11]) ? sense :
                    ((hit_last[s] || hit_err[s] || swreset) ? 1'b0 : en_q[s]);
        ie_q[s]  <= (wr_cmd[s] && bus_wdata[12]) ? sense : ie_q[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; fcnt_q <= '0;
    end else if (swreset) begin
      wp_q <= '0; rp_q <= '0; fcnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + PW'(1);
      if (pop)  rp_q <= rp_q + PW'(1);
      fcnt_q <= fcnt_q + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo_q[wp_q] <= push_data;
  end

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < 2; s++) begin
      if (bus_addr == reg_ofs(s, 0)) bus_rdata = 32'(addr_q[s]);
      if (bus_addr == reg_ofs(s, 1)) bus_rdata = 32'(cnt_q[s]);
      if (bus_addr == reg_ofs(s, 2))
        bus_rdata = {16'b0, 3'b0, ie_q[s], en_q[s], tc_q[s], dir_q[s], ifl_q[s], 8'b0};
    end
    if (bus_addr == CTL_OFS)
      bus_rdata = {17'b0, frozen_q, berr_q, cie_q, 1'b0, pause_q, flush_q, chan_irq, 7'b0, act_q};
  end

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !bus_wr) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && (!mem_we || $stable(mem_wdata))));

  a_r9_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (!mem_req && !pin_ready && !pout_valid));

  a_r9_frozen_cause: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> (pause_q || berr_q));

  a_r4_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= (PW+1)'(DEPTH));

  a_r7_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (last && en_q[~act_q] && !bus_wr) |=> (act_q != $past(act_q)));

  a_r12_error_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_err && !bus_wr) |=> (berr_q && frozen_q && !mem_req));

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && fifo_empty && !bus_wr) |=> !flush_q);

endmodule

// File: tb/tb_dma_pingpong_chan.sv
module tb_dma_pingpong_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h0800, DIR = 32'h0200, IE = 32'h1000, IFL = 32'h0100, TC = 32'h0400;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic mem_req, mem_we, mem_gnt = 0, mem_err = 0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic pin_valid = 0, pin_ready, pout_valid, pout_ready = 1, irq;
  logic [7:0] pin_data = 0, pout_data;

  dma_pingpong_chan dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .pin_valid(pin_valid), .pin_data(pin_data), .pin_ready(pin_ready),
    .pout_valid(pout_valid), .pout_data(pout_data), .pout_ready(pout_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] mem [256];
  logic [7:0] src_buf [16];
  logic [7:0] sink_buf [16];
  int src_len = 0, src_idx = 0, sink_n = 0;
  int gnt_mode = 0, sink_mode = 0;
  logic err_arm = 0;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    mem_gnt = (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? ~mem_gnt : 1'b0;
    mem_err = err_arm && mem_req;
    pin_valid = src_idx < src_len;
    pin_data = src_buf[src_idx[3:0]];
    pout_ready = (sink_mode == 0) ? 1'b1 : ~pout_ready;
    #1;
    if (mem_req && mem_gnt) begin
      if (mem_err) err_arm = 0;
      else if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
    end
    if (pin_valid && pin_ready) src_idx++;
    if (pout_valid && pout_ready) begin
      sink_buf[sink_n[3:0]] = pout_data;
      sink_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic setup(input int s, input logic [31:0] a, input logic [31:0] n, input logic [31:0] bits);
    wr(6'(s*16), a);
    wr(6'(s*16 + 4), n);
    wr(6'(s*16 + 8), 32'h1F00);
    wr(6'(s*16 + 8), 32'h8000 | bits);
  endtask

  task automatic chan_reset();
    wr(6'h20, 32'h7E00);
    wr(6'h20, 32'h8800);
  endtask

  task automatic wait_sink(input int n, input string tag);
    for (int k = 0; k < 3000 && sink_n < n; k++) @(negedge clk);
    chk(tag, 32'(sink_n), 32'(n));
  endtask

  task automatic wait_tc(input int s, input string tag);
    logic [31:0] v;
    v = 0;
    for (int k = 0; k < 3000 && !v[10]; k++) rd(6'(s*16 + 8), v);
    chk(tag, {31'b0, v[10]}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(6'h20, v); chk("R1 control after reset", v, 0);
    rd(6'h08, v); chk("R1 cmd0 after reset", v, 0);
    rd(6'h18, v); chk("R1 cmd1 after reset", v, 0);
    chk("R1 outputs idle", {28'b0, irq, mem_req, pin_ready, pout_valid}, 0);

    wr(6'h18, 32'h9200); rd(6'h18, v); chk("R2 sense set", v, 32'h1200);
    wr(6'h18, 32'h0200); rd(6'h18, v); chk("R2 sense clear", v, 32'h1000);
    wr(6'h18, 32'h0000); rd(6'h18, v); chk("R2 zero bits unchanged", v, 32'h1000);
    wr(6'h18, 32'h8000); rd(6'h18, v); chk("R2 bit15 reads 0", v, 32'h1000);
    wr(6'h18, 32'h1000);
    wr(6'h10, 32'h0000BEEF); wr(6'h14, 32'h1234); wr(6'h00, 32'h55);
    rd(6'h10, v); chk("R3 slot1 address", v, 32'hBEEF);
    rd(6'h14, v); chk("R3 slot1 count", v, 32'h1234);
    rd(6'h00, v); chk("R3 slot0 address", v, 32'h55);

    for (int gm = 0; gm < 2; gm++)
      for (int sm = 0; sm < 2; sm++)
        for (int len = 1; len <= 6; len++) begin
          chan_reset();
          gnt_mode = gm; sink_mode = sm; sink_n = 0;
          setup(0, 32'(16 * len), 32'(len), EN | IE);
          wait_sink(len, "R5 outbound byte count");
          bad = 0;
          for (int i = 0; i < len; i++) if (sink_buf[i] != mem[16*len + i]) bad++;
          chk("R5 outbound bytes in order", 32'(bad), 0);
          rd(6'h08, v); chk("R6 outbound done status", v, IFL | TC | IE);
          rd(6'h04, v); chk("R5 count drained", v, 0);
          rd(6'h00, v); chk("R5 address advanced", v, 32'(17 * len));
        end

    for (int gm = 0; gm < 2; gm++)
      for (int len = 1; len <= 6; len++) begin
        chan_reset();
        gnt_mode = gm;
        for (int i = 0; i < 16; i++) src_buf[i] = 8'(8'hA0 + i * 5 + len);
        for (int i = 0; i < 8; i++) mem[8'h80 + i] = 0;
        src_idx = 0; src_len = len;
        setup(0, 32'h80, 32'(len), EN | IE | DIR);
        wait_tc(0, "R6 inbound reaches terminal count");
        bad = 0;
        for (int i = 0; i < len; i++) if (mem[8'h80 + i] != src_buf[i]) bad++;
        chk("R4 inbound bytes stored", 32'(bad), 0);
        chk("R4 inbound bytes consumed", 32'(src_idx), 32'(len));
        chk("R4 no write past count", 32'(mem[8'h80 + len]), 0);
        rd(6'h08, v); chk("R6 inbound done status", v, IFL | TC | IE | DIR);
      end

    chk("R8 irq gated off", {31'b0, irq}, 0);
    wr(6'h20, 32'h9000);
    rd(6'h20, v); chk("R8 control irq bit", v, 32'h1100);
    chk("R8 irq raised", {31'b0, irq}, 1);
    wr(6'h08, 32'h0100);
    rd(6'h20, v); chk("R8 flag cleared drops irq", v, 32'h1000);
    chk("R8 irq low", {31'b0, irq}, 0);

    chan_reset();
    gnt_mode = 1; sink_mode = 0; sink_n = 0; src_len = 0; src_idx = 0;
    setup(1, 32'h40, 2, EN);
    setup(0, 32'h30, 3, EN);
    wait_sink(5, "R7 chained byte count");
    bad = 0;
    for (int i = 0; i < 3; i++) if (sink_buf[i] != mem[8'h30 + i]) bad++;
    for (int i = 0; i < 2; i++) if (sink_buf[3 + i] != mem[8'h40 + i]) bad++;
    chk("R7 chained bytes in order", 32'(bad), 0);
    rd(6'h20, v); chk("R7 active slot switched", v, 32'h1);
    rd(6'h18, v); chk("R7 slot1 done", v, IFL | TC);
    rd(6'h08, v); chk("R7 slot0 done", v, IFL | TC);
    wr(6'h20, 32'h8800);
    rd(6'h20, v); chk("R11 reset selects slot 0", v, 0);

    chan_reset();
    gnt_mode = 0;
    for (int i = 0; i < 8; i++) mem[8'h60 + i] = 0;
    src_buf[0] = 8'h3C; src_buf[1] = 8'hC3; src_idx = 0; src_len = 2;
    setup(0, 32'h60, 8, EN | DIR);
    repeat (20) @(negedge clk);
    chk("R4 partial bytes held", 32'(mem[8'h60]), 0);
    rd(6'h04, v); chk("R4 count untouched before write", v, 8);
    gnt_mode = 2;
    wr(6'h20, 32'h8200);
    rd(6'h20, v); chk("R10 flush reads 1 while draining", v, 32'h0200);
    gnt_mode = 0;
    repeat (10) @(negedge clk);
    rd(6'h20, v); chk("R10 flush self-clears", v, 0);
    chk("R10 flushed bytes", {mem[8'h61], mem[8'h60]}, 32'hC33C);
    rd(6'h04, v); chk("R10 count after flush", v, 6);

    chan_reset();
    gnt_mode = 2; sink_mode = 0; sink_n = 0; src_len = 0; src_idx = 0;
    setup(0, 32'h10, 4, EN);
    repeat (3) @(negedge clk);
    #2 chk("R13 request held", {31'b0, mem_req}, 1);
    wr(6'h20, 32'h8400);
    rd(6'h20, v); chk("R9 not frozen while request held", v, 32'h0400);
    chk("R13 address stable", mem_addr, 32'h10);
    gnt_mode = 0;
    repeat (3) @(negedge clk);
    rd(6'h20, v); chk("R9 frozen after beat", v, 32'h4400);
    rd(6'h04, v); chk("R9 held beat completed", v, 3);
    repeat (5) @(negedge clk);
    rd(6'h04, v); chk("R9 no progress while frozen", v, 3);
    chk("R9 no request while frozen", {31'b0, mem_req}, 0);
    wr(6'h20, 32'h0400);
    wait_sink(4, "R9 resume completes transfer");
    bad = 0;
    for (int i = 0; i < 4; i++) if (sink_buf[i] != mem[8'h10 + i]) bad++;
    chk("R9 bytes after resume", 32'(bad), 0);

    chan_reset();
    src_buf[0] = 8'h11; src_buf[1] = 8'h22; src_idx = 0; src_len = 2;
    setup(0, 32'h70, 8, EN | DIR);
    repeat (10) @(negedge clk);
    wr(6'h20, 32'h8400);
    repeat (3) @(negedge clk);
    wr(6'h04, 0);
    rd(6'h04, v); chk("R11 count written while paused", v, 0);
    wr(6'h20, 32'h8800);
    rd(6'h20, v); chk("R11 reset clears pause and frozen", v, 0);
    rd(6'h08, v); chk("R11 reset disarms slot", v, DIR);
    src_buf[0] = 8'h5A; src_buf[1] = 8'hA5; src_idx = 0; src_len = 2;
    setup(0, 32'h70, 2, EN | DIR);
    wait_tc(0, "R11 transfer after reset");
    chk("R11 stale FIFO bytes discarded", {mem[8'h71], mem[8'h70]}, 32'hA55A);

    chan_reset();
    gnt_mode = 2; sink_n = 0; src_len = 0; src_idx = 0;
    setup(0, 32'h20, 3, EN);
    err_arm = 1;
    gnt_mode = 0;
    repeat (5) @(negedge clk);
    rd(6'h20, v); chk("R12 bus error and frozen", v, 32'h6000);
    rd(6'h08, v); chk("R12 slot disarmed", v, 0);
    rd(6'h04, v); chk("R12 count unchanged", v, 3);
    rd(6'h00, v); chk("R12 address unchanged", v, 32'h20);
    chan_reset();
    rd(6'h20, v); chk("R11 reset clears bus error", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule